// File: doc/BRIEF.md
# Three-Byte Serial DAC Write Master

This block sits on the host side of a serial digital-to-analog converter link. A single-cycle request carries a 16-bit output code and a 2-bit power mode; the block assembles a 24-bit word and sends it on three wires: an active-low frame select, a serial clock and a serial data line. The word is sent as three 8-bit transfers. The select stays low for the whole word, and the serial clock stays low for a short extra pause between the bytes.

All timing is counted in system clocks and set by parameters: the length of each serial-clock half period, the extra pause at each byte boundary, and the minimum time the select stays high between words. The serial clock rests low. The data line changes together with each rising serial-clock edge, so the receiver samples a settled bit on the falling edge. The host sees `busy` for the whole word and the trailing gap. After the gap it sees a one-cycle `done`. An `abort` input ends a word early by raising the select, which makes the receiver discard the word. The block then waits out the same gap and returns to idle without `done`.

Top module: `sdac_frame_writer`

## Requirements
- R1: While reset is held and right after it, `cs_n` is 1 and `sclk`, `sdo`, `busy` and `done` are 0.
- R2: The word holds 24 bits taken on the falling `sclk` edges, most significant bit first: six 0 bits, then `mode[1]`, `mode[0]`, then `code[15]` down to `code[0]`.
- R3: `sclk` is 0 whenever no word is in progress. `sdo` changes only in the cycle where `sclk` rises, and it holds its value for the whole high phase.
- R4: Every high phase of `sclk` lasts exactly HALF_DIV system clocks. Every low phase inside a byte lasts exactly HALF_DIV system clocks.
- R5: The low phase that follows the 8th and the 16th falling edge lasts HALF_DIV+BYTE_GAP system clocks. `cs_n` stays 0 across both pauses.
- R6: `cs_n` falls HALF_DIV system clocks before the first rising `sclk` edge. On a complete word it rises HALF_DIV system clocks after the 24th falling edge.
- R7: Between two words `cs_n` stays high for at least GAP_CYC system clocks. After a complete word, `done` is 1 for exactly one cycle, once `cs_n` has been high for GAP_CYC cycles. In that same cycle `busy` is 0.
- R8: A request while `busy` is 1 is ignored. It does not change the word in progress and does not start another word.
- R9: An `abort` during a word makes `cs_n` 1 and `sclk` 0 in the next cycle. `busy` then stays 1 for GAP_CYC cycles and falls with no `done`. An `abort` while idle has no effect.
- R10: A request while idle makes `cs_n` 0 and `busy` 1 in the next cycle. The word carries the `code` and `mode` present in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a word (used only while idle) |
| code | input | 16 | Output code, captured with req |
| mode | input | 2 | Power mode, captured with req |
| abort | input | 1 | Ends the word in progress |
| busy | output | 1 | Word or trailing gap in progress |
| done | output | 1 | One-cycle pulse after a complete word and its gap |
| cs_n | output | 1 | Active-low frame select |
| sclk | output | 1 | Serial clock, rests low |
| sdo | output | 1 | Serial data, most significant bit first |

## Verification
The assertions assume that `req` and `abort` are synchronous to `clk`. They also assume that `code` and `mode` need to be valid only in the cycle where `req` is taken, and that `abort` is a single-cycle pulse. The bench drives every input on the falling system-clock edge. It pulses `abort` for one cycle, at a random point that is always before the last falling `sclk` edge. It also scrambles `code` and raises `req` again in the middle of a word, which exercises the ignore rule without ever breaking these assumptions.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_HIGH  = 3'd2,
    ST_LOW   = 3'd3,
    ST_GAP   = 3'd4
  } wr_state_t;
endpackage

// File: rtl/sdac_frame_builder.sv
module sdac_frame_builder #(
  parameter int CODE_W = 16,
  parameter int MODE_W = 2,
  parameter int PAD_W  = 6,
  localparam int FRAME_W = PAD_W + MODE_W + CODE_W
) (
  input  logic [CODE_W-1:0]  code,
  input  logic [MODE_W-1:0]  mode,
  output logic [FRAME_W-1:0] frame
);
  // pad bits at the top, mode next, code at the bottom
  genvar gi;
  generate
    for (gi = 0; gi < PAD_W; gi++) begin : g_pad
      assign frame[FRAME_W-1-gi] = 1'b0;
    end
  endgenerate
  assign frame[MODE_W+CODE_W-1:CODE_W] = mode;
  assign frame[CODE_W-1:0]             = code;
endmodule

// File: rtl/sdac_bit_shifter.sv
module sdac_bit_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);
  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = din;
    else if (shift) sh_d = {sh_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sh_q <= '0;
    else if (load || shift)  sh_q <= sh_d;
  end

  assign msb = sh_q[W-1];

  p_no_load_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));
endmodule

// File: rtl/sdac_phase_timer.sv
module sdac_phase_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = len - TW'(1);
    else if (cnt_q != '0)   cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  p_len_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (len != '0));
endmodule

// File: rtl/sdac_frame_writer.sv
module sdac_frame_writer #(
  parameter int CODE_W   = 16,
  parameter int MODE_W   = 2,
  parameter int PAD_W    = 6,
  parameter int BYTE_W   = 8,
  parameter int HALF_DIV = 4,
  parameter int BYTE_GAP = 4,
  parameter int GAP_CYC  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [CODE_W-1:0] code,
  input  logic [MODE_W-1:0] mode,
  input  logic              abort,
  output logic              busy,
  output logic              done,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdo
);
  import sdac_pkg::*;

  localparam int FRAME_W = PAD_W + MODE_W + CODE_W;
  localparam int BC_W    = $clog2(FRAME_W + 1);
  localparam int LEN_A   = HALF_DIV + BYTE_GAP;
  localparam int LEN_MAX = (LEN_A > GAP_CYC) ? LEN_A : GAP_CYC;
  localparam int TW      = $clog2(LEN_MAX + 1);

  localparam logic [TW-1:0] HALF_LEN  = TW'(HALF_DIV);
  localparam logic [TW-1:0] PAUSE_LEN = TW'(LEN_A);
  localparam logic [TW-1:0] GAP_LEN   = TW'(GAP_CYC);

  wr_state_t       state_q, state_d;
  logic            cs_n_q, cs_n_d;
  logic            sclk_q, sclk_d;
  logic            sdo_q, sdo_d;
  logic            done_q, done_d;
  logic            abt_q, abt_d;
  logic [BC_W-1:0] bit_q, bit_d;

  logic               t_load, t_exp;
  logic [TW-1:0]      t_len;
  logic               sh_load, sh_shift, sh_msb;
  logic [FRAME_W-1:0] frame;
  logic               last_bit, byte_edge;

  sdac_frame_builder #(
    .CODE_W(CODE_W), .MODE_W(MODE_W), .PAD_W(PAD_W)
  ) u_build (
    .code (code),
    .mode (mode),
    .frame(frame)
  );

  sdac_bit_shifter #(.W(FRAME_W)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .load (sh_load),
    .shift(sh_shift),
    .din  (frame),
    .msb  (sh_msb)
  );

  sdac_phase_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (t_load),
    .len    (t_len),
    .expired(t_exp)
  );

  assign last_bit  = (bit_q == BC_W'(FRAME_W));
  assign byte_edge = ((32'(bit_q) % BYTE_W) == 0) && !last_bit;

  always_comb begin
    state_d  = state_q;
    cs_n_d   = cs_n_q;
    sclk_d   = sclk_q;
    sdo_d    = sdo_q;
    done_d   = 1'b0;
    abt_d    = abt_q;
    bit_d    = bit_q;
    t_load   = 1'b0;
    t_len    = HALF_LEN;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          state_d = ST_SETUP;
          cs_n_d  = 1'b0;
          sh_load = 1'b1;
          t_load  = 1'b1;
          bit_d   = '0;
          abt_d   = 1'b0;
        end
      end
      ST_SETUP, ST_LOW: begin
        if (abort) begin
          state_d = ST_GAP;
          cs_n_d  = 1'b1;
          sclk_d  = 1'b0;
          sdo_d   = 1'b0;
          abt_d   = 1'b1;
          t_load  = 1'b1;
          t_len   = GAP_LEN;
        end else if (t_exp) begin
          if (state_q == ST_LOW && last_bit) begin
            state_d = ST_GAP;
            cs_n_d  = 1'b1;
            sdo_d   = 1'b0;
            t_load  = 1'b1;
            t_len   = GAP_LEN;
          end else begin
            state_d  = ST_HIGH;
            sclk_d   = 1'b1;
            sdo_d    = sh_msb;
            sh_shift = 1'b1;
            bit_d    = bit_q + BC_W'(1);
            t_load   = 1'b1;
          end
        end
      end
      ST_HIGH: begin
        if (abort) begin
          state_d = ST_GAP;
          cs_n_d  = 1'b1;
          sclk_d  = 1'b0;
          sdo_d   = 1'b0;
          abt_d   = 1'b1;
          t_load  = 1'b1;
          t_len   = GAP_LEN;
        end else if (t_exp) begin
          state_d = ST_LOW;
          sclk_d  = 1'b0;
          t_load  = 1'b1;
          t_len   = byte_edge ? PAUSE_LEN : HALF_LEN;
        end
      end
      ST_GAP: begin
        if (t_exp) begin
          state_d = ST_IDLE;
          done_d  = !abt_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      sdo_q   <= 1'b0;
      done_q  <= 1'b0;
      abt_q   <= 1'b0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      sdo_q   <= sdo_d;
      done_q  <= done_d;
      abt_q   <= abt_d;
      bit_q   <= bit_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign cs_n = cs_n_q;
  assign sclk = sclk_q;
  assign sdo  = sdo_q;

  // checker state: select-high run, serial high run, falling edges per word
  logic [TW-1:0]   gap_q, hi_q;
  logic [BC_W-1:0] fall_q;
  logic            sclk_p_q, cs_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q    <= GAP_LEN;
      hi_q     <= '0;
      fall_q   <= '0;
      sclk_p_q <= 1'b0;
      cs_p_q   <= 1'b1;
    end else begin
      sclk_p_q <= sclk_q;
      cs_p_q   <= cs_n_q;
      if (!cs_n_q)              gap_q <= '0;
      else if (gap_q != GAP_LEN) gap_q <= gap_q + TW'(1);
      if (sclk_q) hi_q <= hi_q + TW'(1);
      else        hi_q <= '0;
      if (cs_p_q && !cs_n_q)         fall_q <= '0;
      else if (sclk_p_q && !sclk_q)  fall_q <= fall_q + BC_W'(1);
    end
  end

  p_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (fall_q == BC_W'(FRAME_W)));
  p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(sdo_q));
  p_hi_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk_q) && !$rose(cs_n_q)) |-> (hi_q == HALF_LEN));
  p_sclk_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> !cs_n_q);
  p_gap_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> (gap_q == GAP_LEN));
  p_done_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cs_n_q && gap_q == GAP_LEN && !busy));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> $past(req && !busy));
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !cs_n_q) |=> (cs_n_q && !sclk_q));
  p_req_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> (!cs_n_q && busy));
endmodule

// File: tb/sdac_frame_writer_tb.sv
module sdac_frame_writer_tb;
  localparam int HALF_DIV = 4;
  localparam int BYTE_GAP = 4;
  localparam int GAP_CYC  = 7;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] code = '0;
  logic [1:0]  mode = '0;
  logic        abort = 1'b0;
  logic        busy, done, cs_n, sclk, sdo;

  int checks = 0;
  int errors = 0;
  bit aborting = 1'b0;

  always #2.5 clk = ~clk;

  sdac_frame_writer #(
    .HALF_DIV(HALF_DIV), .BYTE_GAP(BYTE_GAP), .GAP_CYC(GAP_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .code(code), .mode(mode),
    .abort(abort), .busy(busy), .done(done), .cs_n(cs_n),
    .sclk(sclk), .sdo(sdo)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_word(input logic [15:0] c, input logic [1:0] m);
    return {6'b000000, m, c};
  endfunction

  function automatic int exp_low(input int bits_done);
    return ((bits_done % 8) == 0) ? HALF_DIV + BYTE_GAP : HALF_DIV;
  endfunction

  // line monitor, sampled on the falling system-clock edge
  logic        p_cs = 1'b1, p_sclk = 1'b0, rise_sdo = 1'b0;
  int          cs_run = 0, sclk_run = 0, m_bits = 0;
  logic [23:0] m_word = '0, last_word = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_cs = 1'b1; p_sclk = 1'b0; cs_run = GAP_CYC; sclk_run = 0;
    end else begin
      if (cs_n !== p_cs) begin
        if (!cs_n) begin
          chk(cs_run >= GAP_CYC, "R7 select high gap", cs_run, GAP_CYC);
          m_bits = 0; m_word = '0;
        end else if (!aborting) begin
          chk(m_bits == 24, "R6 bits before select rise", m_bits, 24);
          chk(sclk_run == HALF_DIV, "R6 select rise delay", sclk_run, HALF_DIV);
          last_word = m_word;
        end
      end
      if (sclk !== p_sclk) begin
        if (sclk) begin
          chk(!cs_n, "R5 select low at rise", int'(cs_n), 0);
          if (m_bits == 0)
            chk(cs_run == HALF_DIV, "R6 select setup", cs_run, HALF_DIV);
          else
            chk(sclk_run == exp_low(m_bits), "R4 R5 low phase", sclk_run, exp_low(m_bits));
          rise_sdo = sdo;
        end else if (!aborting) begin
          chk(sclk_run == HALF_DIV, "R4 high phase", sclk_run, HALF_DIV);
          chk(sdo == rise_sdo, "R3 data stable in high", int'(sdo), int'(rise_sdo));
          m_word = {m_word[22:0], sdo};
          m_bits++;
        end
      end else if (!sclk && !cs_n && cs_n === p_cs && m_bits > 0 && !aborting) begin
        chk(sdo == rise_sdo, "R3 data stable in low", int'(sdo), int'(rise_sdo));
      end
      if (cs_n && !busy)
        chk(!sclk, "R3 clock rests low", int'(sclk), 0);
      if (done) begin
        chk(cs_n && cs_run == GAP_CYC, "R7 done after gap", cs_run, GAP_CYC);
        chk(!busy, "R7 busy low with done", int'(busy), 0);
      end
      cs_run   = (cs_n !== p_cs) ? 1 : cs_run + 1;
      sclk_run = (sclk !== p_sclk) ? 1 : sclk_run + 1;
      p_cs = cs_n; p_sclk = sclk;
    end
  end

  task automatic send(input logic [15:0] c, input logic [1:0] m, input bit scramble);
    logic [23:0] exp;
    exp = exp_word(c, m);
    @(negedge clk);
    while (busy) @(negedge clk);
    code = c; mode = m; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(!cs_n && busy, "R10 start next cycle", int'({cs_n, busy}), 1);
    code = ~c; mode = ~m;
    if (scramble) begin
      repeat (10) @(negedge clk);
      req = 1'b1; code = 16'($urandom); mode = 2'($urandom);
      @(negedge clk);
      req = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(last_word == exp, "R2 word content", int'(last_word), int'(exp));
    @(negedge clk);
    chk(!done, "R7 done single cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(cs_n && !busy, "R8 no extra word", int'({cs_n, busy}), 2);
  endtask

  task automatic abort_run(input int delay);
    int n;
    @(negedge clk);
    while (busy) @(negedge clk);
    code = 16'($urandom); mode = 2'($urandom); req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (delay) @(negedge clk);
    aborting = 1'b1;
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(cs_n && !sclk, "R9 abort raises select", int'({cs_n, sclk}), 2);
    n = 0;
    while (busy) begin
      n++;
      chk(!done, "R9 no done on abort", int'(done), 0);
      @(negedge clk);
    end
    chk(n == GAP_CYC, "R9 gap after abort", n, GAP_CYC);
    chk(!done, "R9 no done at idle", int'(done), 0);
    aborting = 1'b0;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, WD_LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5DAC_0042));
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !sdo && !busy && !done, "R1 reset state",
        int'({cs_n, sclk, sdo, busy, done}), 16);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && !sdo && !busy && !done, "R1 after release",
        int'({cs_n, sclk, sdo, busy, done}), 16);

    send(16'h0000, 2'b00, 1'b0);
    send(16'hFFFF, 2'b11, 1'b0);
    send(16'h8001, 2'b10, 1'b1);
    send(16'h7FFE, 2'b01, 1'b0);

    // abort while idle must do nothing
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(cs_n && !busy, "R9 idle abort ignored", int'({cs_n, busy}), 2);

    abort_run(1);
    abort_run(HALF_DIV + 1);
    abort_run(60);
    send(16'hA5C3, 2'b01, 1'b0);

    for (int i = 0; i < 20; i++) begin
      send(16'($urandom), 2'($urandom), 1'($urandom));
      if ((i % 5) == 4) abort_run(1 + ($urandom % 150));
    end

    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule